// File: doc/BRIEF.md
# Conditional Load Execution Unit

This unit executes the word-load group of a 32-bit instruction set. It accepts one instruction at a time through a valid/ready handshake. When it accepts an instruction, it samples two things in the same cycle: the register-file read data for the base and offset registers it names, and the current status flags. It then decides whether the load runs at all. If it runs, the unit forms the effective address and issues a single word read on a request/response memory port. When the response arrives, it reports the destination register write and an optional base-register update.

Six load opcodes exist, made of two offset sources and three indexing modes. The two offset sources are a signed immediate and a register. The three modes are plain, pre-indexed with writeback, and post-indexed. A 4-bit condition field can turn any load into a no-op.

A load can fault for two reasons: the memory rejects the access, or the unit finds a misaligned address before issuing the request. A faulting load produces no register write, so the trap handler can replay it and get the same result. Loads never change the status flags.

Top module: `cond_load_unit`

## Requirements
- R1: After reset the unit is idle. `in_ready` is 1, and `done`, `mem_req`, `rd_we` and `base_we` are 0.
- R2: Opcode 0x0 and opcodes 0x07 to 0x7F are no-ops, whatever is in bits [31:7]. They issue no memory request and assert `done` in the cycle after acceptance with no register write and no fault.
- R3: The condition field in bits [10:7] is evaluated against `status_flags` = {N,Z,C,V}. The codes are: 0 always, 1 Z=1, 2 Z=0, 3 N!=V, 4 N=V, 5 C=0, 6 C=1, and 7 to 15 never. A failed condition behaves exactly like the no-ops of R2.
- R4: Opcodes 0x1 to 0x3 take the 11-bit offset in bits [31:21] and sign-extend it. Opcode 0x1 reads memory at src + offset and writes the returned word to dst (bits [15:11]), with no base write.
- R5: Opcodes 0x4 to 0x6 use the full 32-bit value of the register indexed by bits [25:21] as the offset. `rf_src_idx` shows bits [20:16] and `rf_off_idx` shows bits [25:21] of `in_instr`. Opcode 0x4 reads memory at src + offset and writes the word to dst.
- R6: Opcodes 0x2 and 0x5 (pre-indexed) read memory at src + offset and also write that address back to src (`base_idx` = bits [20:16]).
- R7: Opcodes 0x3 and 0x6 (post-indexed) read memory at the unmodified src value and write src + offset back to src.
- R8: An effective address with non-zero low two bits ends the load with `fault`=1 and `done`=1 in the cycle after acceptance. No memory request is made and no register is written.
- R9: A memory response with `mem_rsp_fault`=1 ends the load with `fault`=1 and no register write.
- R10: `in_ready` is 0 from acceptance until `done`. Instructions presented while busy are ignored.
- R11: `done` lasts exactly one cycle per instruction. `mem_req` lasts exactly one cycle per issued load, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, will accept |
| in_instr | input | 32 | Instruction word |
| rf_src_idx | output | 5 | Base register read index (from in_instr) |
| rf_off_idx | output | 5 | Offset register read index (from in_instr) |
| rf_src_data | input | 32 | Base register value |
| rf_off_data | input | 32 | Offset register value |
| status_flags | input | 4 | {N,Z,C,V} |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_fault | input | 1 | Access rejected |
| done | output | 1 | Instruction complete (one cycle) |
| fault | output | 1 | Memory fault on completion |
| rd_we | output | 1 | Destination write enable |
| rd_idx | output | 5 | Destination index |
| rd_data | output | 32 | Loaded word |
| base_we | output | 1 | Base writeback enable |
| base_idx | output | 5 | Base register index |
| base_data | output | 32 | Updated base value |

## Verification
A wrong decision about whether to run shows up one cycle after acceptance: either a `mem_req` pulse appears where `done` was expected, or `done` arrives early. A wrong offset or indexing mode shows up in `mem_addr` during that same request cycle. A base value that was captured wrongly stays hidden until the completion cycle, where `base_data` shows it. A stuck or leaking state shows up as `in_ready` staying low, as `done` lasting longer than one cycle, or as a busy-time instruction triggering a second request one cycle after `done`.

// File: rtl/cld_pkg.sv
package cld_pkg;

  typedef enum logic [1:0] {
    IDX_PLAIN = 2'd0,
    IDX_PRE   = 2'd1,
    IDX_POST  = 2'd2
  } cld_idx_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } cld_state_e;

  // flags = {N, Z, C, V}
  function automatic logic cond_pass(input logic [3:0] code, input logic [3:0] flags);
    logic n, z, c, v;
    {n, z, c, v} = flags;
    case (code)
      4'd0:    return 1'b1;
      4'd1:    return z;
      4'd2:    return !z;
      4'd3:    return n ^ v;
      4'd4:    return !(n ^ v);
      4'd5:    return !c;
      4'd6:    return c;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cld_decode.sv
module cld_decode
  import cld_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int OPC_W   = 7,
  parameter int IDX_W   = 5,
  parameter int IMM_W   = 11
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [3:0]         flags,
  output logic               is_load,
  output logic               cond_ok,
  output logic               use_reg,
  output cld_idx_e           mode,
  output logic [IDX_W-1:0]   dst,
  output logic [IDX_W-1:0]   src,
  output logic [IDX_W-1:0]   off_idx,
  output logic [IMM_W-1:0]   imm
);
  localparam int COND_LO = OPC_W;
  localparam int DST_LO  = COND_LO + 4;
  localparam int SRC_LO  = DST_LO + IDX_W;
  localparam int OFF_LO  = SRC_LO + IDX_W;

  logic [OPC_W-1:0] opc;
  assign opc     = instr[OPC_W-1:0];
  assign dst     = instr[DST_LO +: IDX_W];
  assign src     = instr[SRC_LO +: IDX_W];
  assign off_idx = instr[OFF_LO +: IDX_W];
  assign imm     = instr[OFF_LO +: IMM_W];
  assign cond_ok = cond_pass(instr[COND_LO +: 4], flags);

  always_comb begin
    is_load = 1'b1;
    use_reg = 1'b0;
    mode    = IDX_PLAIN;
    case (opc)
      7'd1: mode = IDX_PLAIN;
      7'd2: mode = IDX_PRE;
      7'd3: mode = IDX_POST;
      7'd4: begin use_reg = 1'b1; mode = IDX_PLAIN; end
      7'd5: begin use_reg = 1'b1; mode = IDX_PRE;   end
      7'd6: begin use_reg = 1'b1; mode = IDX_POST;  end
      default: is_load = 1'b0;
    endcase
  end
endmodule

// File: rtl/cld_agen.sv
module cld_agen
  import cld_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 11,
  parameter int ALIGN_B = 2
) (
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] reg_off,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_reg,
  input  cld_idx_e          mode,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] base_new,
  output logic              misaligned
);
  function automatic logic [DATA_W-1:0] sext(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] add_off(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  logic [DATA_W-1:0] off_val;
  assign off_val    = use_reg ? reg_off : sext(imm);
  assign base_new   = add_off(src_val, off_val);
  assign addr       = (mode == IDX_POST) ? src_val : base_new;
  assign misaligned = |addr[ALIGN_B-1:0];
endmodule

// File: rtl/cld_ctrl.sv
module cld_ctrl
  import cld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       issue,
  input  logic       rsp_valid,
  output cld_state_e state
);
  cld_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (accept) nxt = issue ? ST_ISSUE : ST_DONE;
      ST_ISSUE: nxt = ST_WAIT;
      ST_WAIT:  if (rsp_valid) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/cond_load_unit.sv
module cond_load_unit
  import cld_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int IMM_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  output logic [IDX_W-1:0]  rf_src_idx,
  output logic [IDX_W-1:0]  rf_off_idx,
  input  logic [DATA_W-1:0] rf_src_data,
  input  logic [DATA_W-1:0] rf_off_data,
  input  logic [3:0]        status_flags,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_fault,
  output logic              done,
  output logic              fault,
  output logic              rd_we,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              base_we,
  output logic [IDX_W-1:0]  base_idx,
  output logic [DATA_W-1:0] base_data
);
  logic              is_load, cond_ok, use_reg, misaligned;
  cld_idx_e          mode;
  logic [IDX_W-1:0]  dst, src, off_idx;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] addr, base_new;
  cld_state_e        state;

  // named events for the checker
  logic accept, go_mem, issue, rsp_take;

  cld_decode #(.INSTR_W(32), .OPC_W(7), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_dec (
    .instr(in_instr), .flags(status_flags), .is_load(is_load), .cond_ok(cond_ok),
    .use_reg(use_reg), .mode(mode), .dst(dst), .src(src), .off_idx(off_idx), .imm(imm)
  );

  cld_agen #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ALIGN_B(2)) u_agen (
    .src_val(rf_src_data), .reg_off(rf_off_data), .imm(imm), .use_reg(use_reg),
    .mode(mode), .addr(addr), .base_new(base_new), .misaligned(misaligned)
  );

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign go_mem   = is_load && cond_ok;
  assign issue    = go_mem && !misaligned;
  assign rsp_take = (state == ST_WAIT) && mem_rsp_valid;

  cld_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .issue(issue),
    .rsp_valid(mem_rsp_valid), .state(state)
  );

  logic              r_load, r_fault, r_wb;
  logic [DATA_W-1:0] r_addr, r_base, r_data;
  logic [IDX_W-1:0]  r_dst, r_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_load  <= 1'b0;
      r_fault <= 1'b0;
      r_wb    <= 1'b0;
      r_addr  <= '0;
      r_base  <= '0;
      r_data  <= '0;
      r_dst   <= '0;
      r_src   <= '0;
    end else if (accept) begin
      r_load  <= go_mem;
      r_fault <= go_mem && misaligned;
      r_wb    <= (mode != IDX_PLAIN);
      r_addr  <= addr;
      r_base  <= base_new;
      r_dst   <= dst;
      r_src   <= src;
    end else if (rsp_take) begin
      r_data  <= mem_rsp_data;
      r_fault <= mem_rsp_fault;
    end
  end

  assign rf_src_idx = src;
  assign rf_off_idx = off_idx;
  assign mem_req    = (state == ST_ISSUE);
  assign mem_addr   = r_addr;
  assign done       = (state == ST_DONE);
  assign fault      = done && r_fault;
  assign rd_we      = done && r_load && !r_fault;
  assign rd_idx     = r_dst;
  assign rd_data    = r_data;
  assign base_we    = rd_we && r_wb;
  assign base_idx   = r_src;
  assign base_data  = r_base;
endmodule

// File: rtl/cld_checker.sv
module cld_checker (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic accept,
  input logic go_mem,
  input logic mem_req,
  input logic done,
  input logic fault,
  input logic rd_we,
  input logic base_we
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_busy_on_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  assert_noop_quick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !go_mem) |=> (done && !mem_req && !rd_we && !fault));

  assert_fault_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!rd_we && !base_we));

  assert_base_needs_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> (rd_we && done));

  assert_done_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);
endmodule

bind cond_load_unit cld_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .accept(accept), .go_mem(go_mem),
  .mem_req(mem_req), .done(done), .fault(fault), .rd_we(rd_we), .base_we(base_we)
);

// File: tb/cond_load_unit_tb.sv
module cond_load_unit_tb;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        in_valid = 0, in_ready;
  logic [31:0] in_instr = 0;
  logic [4:0]  rf_src_idx, rf_off_idx, rd_idx, base_idx;
  logic [31:0] rf_src_data = 0, rf_off_data = 0;
  logic [3:0]  status_flags = 0;
  logic        mem_req, mem_rsp_valid = 0, mem_rsp_fault = 0;
  logic [31:0] mem_addr, mem_rsp_data = 0;
  logic        done, fault, rd_we, base_we;
  logic [31:0] rd_data, base_data;

  int n_chk = 0, n_err = 0;

  cond_load_unit u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(int op, int cc, int d, int s, int off);
    logic [10:0] o = off[10:0];
    return {o, s[4:0], d[4:0], cc[3:0], op[6:0]};
  endfunction

  function automatic logic [31:0] enc_r(int op, int cc, int d, int s, int r);
    return {6'h2A, r[4:0], s[4:0], d[4:0], cc[3:0], op[6:0]};
  endfunction

  // reference model: one instruction, compared cycle by cycle
  task automatic run(input logic [31:0] ins, input logic [31:0] sv, input logic [31:0] ov,
                     input logic [3:0] fl, input int lat, input bit rf, input logic [31:0] rdv);
    int op = int'(ins[6:0]);
    int cc = int'(ins[10:7]);
    bit n = fl[3], z = fl[2], c = fl[1], v = fl[0];
    bit pass, ld, go, mis, wb, post;
    logic [31:0] off, sum, adr;
    case (cc)
      0: pass = 1;
      1: pass = z;
      2: pass = !z;
      3: pass = (n != v);
      4: pass = (n == v);
      5: pass = !c;
      6: pass = c;
      default: pass = 0;
    endcase
    ld   = (op >= 1 && op <= 6);
    go   = ld && pass;
    post = (op == 3 || op == 6);
    wb   = (op == 2 || op == 3 || op == 5 || op == 6);
    off  = (op <= 3) ? 32'($signed(ins[31:21])) : ov;
    sum  = sv + off;
    adr  = post ? sv : sum;
    mis  = (adr % 4) != 0;

    @(negedge clk);
    chk(in_ready === 1'b1, "R10 ready when idle", 32'(in_ready), 1);
    in_valid = 1; in_instr = ins; rf_src_data = sv; rf_off_data = ov; status_flags = fl;
    #1;
    chk(rf_src_idx === ins[20:16] && rf_off_idx === ins[25:21], "R5 read indexes",
        {rf_src_idx, rf_off_idx}, {ins[20:16], ins[25:21]});
    @(negedge clk);
    in_valid = 0;
    if (!go || mis) begin
      chk(mem_req === 1'b0, "R2/R3/R8 no request", 32'(mem_req), 0);
      chk(done === 1'b1, "R2/R3/R8 done", 32'(done), 1);
      chk(rd_we === 1'b0 && base_we === 1'b0, "R2/R3/R8 no write", {rd_we, base_we}, 0);
      chk(fault === (go && mis), "R8 fault flag", 32'(fault), 32'(go && mis));
    end else begin
      chk(mem_req === 1'b1, "R11 request", 32'(mem_req), 1);
      chk(mem_addr === adr, op <= 3 ? "R4 address" : "R5 address", mem_addr, adr);
      // R10: try to slip a load in while busy
      in_valid = 1; in_instr = enc_i(1, 0, 9, 9, 16);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(mem_req === 1'b0 && done === 1'b0, "R11 quiet while waiting", {mem_req, done}, 0);
        chk(in_ready === 1'b0, "R10 busy", 32'(in_ready), 0);
      end
      in_valid = 0;
      mem_rsp_valid = 1; mem_rsp_fault = rf; mem_rsp_data = rdv;
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_fault = 0;
      chk(done === 1'b1, "R11 done", 32'(done), 1);
      chk(fault === rf, "R9 fault", 32'(fault), 32'(rf));
      chk(rd_we === !rf, "R4 dst write", 32'(rd_we), 32'(!rf));
      if (!rf) begin
        chk(rd_idx === ins[15:11] && rd_data === rdv, "R4 dst value", rd_data, rdv);
        chk(base_we === wb, post ? "R7 base we" : "R6 base we", 32'(base_we), 32'(wb));
        if (wb) chk(base_idx === ins[20:16] && base_data === sum,
                    post ? "R7 base value" : "R6 base value", base_data, sum);
      end else begin
        chk(base_we === 1'b0, "R9 no base write", 32'(base_we), 0);
      end
    end
    @(negedge clk);
    chk(done === 1'b0 && mem_req === 1'b0, "R11 done single / R10 ignored", {done, mem_req}, 0);
    chk(in_ready === 1'b1, "R10 idle again", 32'(in_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2;
    chk(in_ready === 1 && done === 0 && mem_req === 0 && rd_we === 0 && base_we === 0,
        "R1 reset state", {in_ready, done, mem_req, rd_we, base_we}, 5'b10000);
    repeat (2) @(negedge clk);
    rst_n = 1;
    run(32'hFFFF_FF80, 32'h100, 0, 4'h0, 1, 0, 0);                      // R2 NOP with junk
    run(enc_i(7'h50, 0, 3, 4, 8), 32'h100, 0, 4'h0, 1, 0, 0);          // R2 unlisted opcode
    run(enc_i(1, 0, 3, 4, 8), 32'h1000, 0, 4'h0, 2, 0, 32'hDEAD_BEEF); // R4
    run(enc_i(1, 0, 6, 2, -4), 32'h2000, 0, 4'h0, 1, 0, 32'h1234_5678);// R4 negative
    run(enc_r(4, 0, 7, 8, 9), 32'h3000, 32'h40, 4'h0, 3, 0, 32'hA5A5_0001); // R5
    run(enc_i(2, 0, 1, 5, 12), 32'h4000, 0, 4'h0, 1, 0, 32'h0BAD_F00D); // R6
    run(enc_r(5, 0, 1, 5, 6), 32'h4000, 32'hFFFF_FFF0, 4'h0, 2, 0, 32'h11); // R6 reg
    run(enc_i(3, 0, 2, 10, 20), 32'h5000, 0, 4'h0, 1, 0, 32'h22);       // R7
    run(enc_r(6, 0, 2, 10, 11), 32'h5004, 32'h8, 4'h0, 4, 0, 32'h33);   // R7 reg
    run(enc_i(1, 1, 3, 4, 0), 32'h100, 0, 4'b0000, 1, 0, 32'h44);       // R3 eq false
    run(enc_i(1, 1, 3, 4, 0), 32'h100, 0, 4'b0100, 1, 0, 32'h44);       // R3 eq true
    run(enc_i(1, 3, 3, 4, 0), 32'h100, 0, 4'b1000, 1, 0, 32'h55);       // R3 lt true
    run(enc_i(1, 4, 3, 4, 0), 32'h100, 0, 4'b1000, 1, 0, 32'h55);       // R3 ge false
    run(enc_i(1, 5, 3, 4, 0), 32'h100, 0, 4'b0010, 1, 0, 32'h55);       // R3 ltu false
    run(enc_i(1, 6, 3, 4, 0), 32'h100, 0, 4'b0010, 1, 0, 32'h66);       // R3 geu true
    run(enc_i(1, 15, 3, 4, 0), 32'h100, 0, 4'b1111, 1, 0, 32'h66);      // R3 reserved
    run(enc_i(1, 0, 3, 4, 2), 32'h100, 0, 4'h0, 1, 0, 0);               // R8 misaligned
    run(enc_i(3, 0, 3, 4, 4), 32'h101, 0, 4'h0, 1, 0, 0);               // R8 post misaligned
    run(enc_i(2, 0, 3, 4, 4), 32'h100, 0, 4'h0, 2, 1, 32'h77);          // R9 memory fault
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule